// File: doc/BRIEF.md
# Coin Acceptor Credit Sequencer

This block tracks how much money a customer has put into a vending machine that accepts only two coin types, ten-cent and twenty-five-cent pieces. Each coin arrives as a single-cycle pulse that is sampled on a rising clock edge. The block advances a small credit register until at least thirty-five cents has been collected. At that point it raises a `paid` flag and holds it. Any amount beyond thirty-five cents is absorbed, because the credit saturates rather than counting up. Only an active-high synchronous clear returns the block to zero credit. The same clear also serves as power-on initialisation.

The credit is held in three flip-flops and is also brought out as a code, so the surrounding controller can see partial progress. The code values are:

| Credit | Code |
|---|---|
| zero | 000 |
| ten | 001 |
| twenty | 010 |
| twenty-five | 011 |
| thirty | 100 |
| thirty-five (final) | 101 |

The two spare codes, 110 and 111, behave as final states: they raise `paid`, they hold on coins, and the clear removes them.

When several inputs are raised in the same cycle, they are resolved by fixed priority:
1. clear,
2. quarter,
3. dime.

Top module: `coin_acceptor_fsm`

## Requirements
- R1: When `clear` is high at a rising edge, `credit_code` becomes 000 and `paid` becomes 0 on that edge. This happens from every state and regardless of the coin inputs.
- R2: A dime pulse alone moves the credit code as follows: 000→001, 001→010, 010→100, 011→101 and 100→101.
- R3: A quarter pulse moves the credit code as follows: 000→011, and each of 001, 010, 011 and 100 goes to 101.
- R4: When `dime_in` and `quarter_in` are both high without `clear`, the result is exactly that of a quarter alone, and the dime is discarded.
- R5: A cycle with none of `clear`, `dime_in` or `quarter_in` high leaves `credit_code` unchanged.
- R6: Once the code is 101, any coin combination without `clear` leaves it at 101, however many coins follow.
- R7: `paid` is 1 exactly when `credit_code` is 101, 110 or 111, and 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Active-high synchronous return to zero credit |
| dime_in | input | 1 | Ten-cent coin pulse, one cycle |
| quarter_in | input | 1 | Twenty-five-cent coin pulse, one cycle |
| credit_code | output | 3 | Registered credit code |
| paid | output | 1 | High once thirty-five cents has been collected |

## Verification
The bench reaches each of the six reachable credit codes and, from each one, applies all eight combinations of clear, dime and quarter. It then compares the next code and the flag against a bench reference model.

Specific faults and how they show:
- A design that let a coin outrank the clear would leave nonzero credit after a clear.
- A design that let the dime win a simultaneous insertion would land on a ten-cent step instead of twenty-five.
- The thirty-cent code shares its top bit with the final codes, so a flag decoded from that bit alone would read as paid at thirty cents.
- Repeated overpayment after reaching the final code checks that the credit neither wraps nor drifts into a spare code.

// File: rtl/coin_pkg.sv
package coin_pkg;

    localparam int CODE_W = 3;

    typedef logic [CODE_W-1:0] credit_t;

    localparam credit_t CR_ZERO   = 3'b000;
    localparam credit_t CR_TEN    = 3'b001;
    localparam credit_t CR_TWENTY = 3'b010;
    localparam credit_t CR_QUART  = 3'b011;
    localparam credit_t CR_THIRTY = 3'b100;
    localparam credit_t CR_FULL   = 3'b101;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_DIME    = 2'd1,
        EV_QUARTER = 2'd2,
        EV_CLEAR   = 2'd3
    } coin_ev_e;

    typedef struct packed {
        logic clear;
        logic dime;
        logic quarter;
    } coin_in_t;

    // Final when the top bit is set, except the thirty-cent code.
    function automatic logic is_final(credit_t c);
        return c[CODE_W-1] & (c[1] | c[0]);
    endfunction

    function automatic credit_t add_dime(credit_t c);
        credit_t n;
        unique case (c)
            CR_ZERO:   n = CR_TEN;
            CR_TEN:    n = CR_TWENTY;
            CR_TWENTY: n = CR_THIRTY;
            CR_QUART:  n = CR_FULL;
            CR_THIRTY: n = CR_FULL;
            default:   n = c;
        endcase
        return n;
    endfunction

    function automatic credit_t add_quarter(credit_t c);
        credit_t n;
        if (c == CR_ZERO)
            n = CR_QUART;
        else if (is_final(c))
            n = c;
        else
            n = CR_FULL;
        return n;
    endfunction

endpackage

// File: rtl/coin_event_arbiter.sv
module coin_event_arbiter
    import coin_pkg::*;
(
    input  coin_in_t raw,
    output coin_ev_e ev
);
    always_comb begin
        if (raw.clear)
            ev = EV_CLEAR;
        else if (raw.quarter)
            ev = EV_QUARTER;
        else if (raw.dime)
            ev = EV_DIME;
        else
            ev = EV_NONE;
    end
endmodule

// File: rtl/coin_next_state.sv
module coin_next_state
    import coin_pkg::*;
(
    input  credit_t  cur,
    input  coin_ev_e ev,
    output credit_t  nxt
);
    always_comb begin
        unique case (ev)
            EV_CLEAR:   nxt = CR_ZERO;
            EV_QUARTER: nxt = add_quarter(cur);
            EV_DIME:    nxt = add_dime(cur);
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/coin_state_reg.sv
module coin_state_reg
    import coin_pkg::*;
(
    input  logic    clk,
    input  credit_t d,
    output credit_t q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/coin_acceptor_fsm.sv
module coin_acceptor_fsm
    import coin_pkg::*;
(
    input  logic       clk,
    input  logic       clear,
    input  logic       dime_in,
    input  logic       quarter_in,
    output logic [2:0] credit_code,
    output logic       paid
);
    coin_in_t raw;
    coin_ev_e ev;
    credit_t  cur;
    credit_t  nxt;

    assign raw = '{clear: clear, dime: dime_in, quarter: quarter_in};

    coin_event_arbiter u_arb (.raw(raw), .ev(ev));
    coin_next_state    u_ns  (.cur(cur), .ev(ev), .nxt(nxt));
    coin_state_reg     u_reg (.clk(clk), .d(nxt), .q(cur));

    assign credit_code = cur;
    assign paid        = is_final(cur);
endmodule

// File: rtl/coin_acceptor_checker.sv
module coin_acceptor_checker (
    input logic       clk,
    input logic       clear,
    input logic       dime_in,
    input logic       quarter_in,
    input logic [2:0] credit_code,
    input logic       paid
);
    logic seen_clear = 1'b0;

    always_ff @(posedge clk) begin
        if (clear) seen_clear <= 1'b1;
    end

    assert_clear_zero_R1: assert property (@(posedge clk)
        clear |=> (credit_code == 3'b000 && !paid));

    assert_dime_start_R2: assert property (@(posedge clk) disable iff (clear || !seen_clear)
        (dime_in && !quarter_in && credit_code == 3'b000) |=> credit_code == 3'b001);

    assert_quarter_full_R3: assert property (@(posedge clk) disable iff (clear || !seen_clear)
        (quarter_in && credit_code != 3'b000 && !paid) |=> credit_code == 3'b101);

    assert_quarter_wins_R4: assert property (@(posedge clk) disable iff (clear || !seen_clear)
        (quarter_in && dime_in && credit_code == 3'b000) |=> credit_code == 3'b011);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (clear || !seen_clear)
        (!dime_in && !quarter_in) |=> $stable(credit_code));

    assert_final_sticky_R6: assert property (@(posedge clk) disable iff (clear || !seen_clear)
        paid |=> (paid && $stable(credit_code)));

    assert_thirty_unpaid_R7: assert property (@(posedge clk) disable iff (!seen_clear)
        (credit_code == 3'b100) |-> !paid);
endmodule

bind coin_acceptor_fsm coin_acceptor_checker u_chk (
    .clk(clk), .clear(clear), .dime_in(dime_in), .quarter_in(quarter_in),
    .credit_code(credit_code), .paid(paid)
);

// File: tb/coin_acceptor_fsm_tb_top.sv
module coin_acceptor_fsm_tb_top;
    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       dime_in = 1'b0;
    logic       quarter_in = 1'b0;
    logic [2:0] credit_code;
    logic       paid;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] model = 3'b000;
    bit done = 1'b0;

    always #10 clk = ~clk;

    coin_acceptor_fsm dut_i (
        .clk(clk), .clear(clear), .dime_in(dime_in), .quarter_in(quarter_in),
        .credit_code(credit_code), .paid(paid)
    );

    function automatic logic [2:0] ref_next(logic [2:0] s, logic c, logic d, logic q);
        if (c) return 3'b000;
        if (q) begin
            if (s == 3'b000) return 3'b011;
            if (s == 3'b101) return 3'b101;
            return 3'b101;
        end
        if (d) begin
            case (s)
                3'b000: return 3'b001;
                3'b001: return 3'b010;
                3'b010: return 3'b100;
                3'b011: return 3'b101;
                3'b100: return 3'b101;
                default: return s;
            endcase
        end
        return s;
    endfunction

    function automatic logic ref_paid(logic [2:0] s);
        return (s == 3'b101) || (s == 3'b110) || (s == 3'b111);
    endfunction

    task automatic step(input logic c, input logic d, input logic q, input string tag);
        @(negedge clk);
        clear = c; dime_in = d; quarter_in = q;
        @(posedge clk);
        model = ref_next(model, c, d, q);
        #2;
        n_cmp++;
        if (credit_code !== model || paid !== ref_paid(model)) begin
            n_bad++;
            $display("FAIL %s: in c=%0b d=%0b q=%0b code=%03b paid=%0b expected code=%03b paid=%0b",
                     tag, c, d, q, credit_code, paid, model, ref_paid(model));
        end
    endtask

    function automatic string tag_of(logic [2:0] s, logic c, logic d, logic q);
        if (c) return "R1";
        if (d && q) return "R4";
        if (!d && !q) return "R5";
        if (s == 3'b101) return "R6";
        if (q) return "R3";
        return "R2";
    endfunction

    task automatic reach(input int idx);
        step(1'b1, 1'b0, 1'b0, "R1");
        case (idx)
            1: step(1'b0, 1'b1, 1'b0, "R2");
            2: begin step(1'b0, 1'b1, 1'b0, "R2"); step(1'b0, 1'b1, 1'b0, "R2"); end
            3: step(1'b0, 1'b0, 1'b1, "R3");
            4: begin
                step(1'b0, 1'b1, 1'b0, "R2"); step(1'b0, 1'b1, 1'b0, "R2");
                step(1'b0, 1'b1, 1'b0, "R7");
            end
            5: begin step(1'b0, 1'b0, 1'b1, "R3"); step(1'b0, 1'b1, 1'b0, "R2"); end
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd4711));
        step(1'b1, 1'b1, 1'b1, "R1");
        // exhaustive state x input sweep
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < 8; k++) begin
                reach(s);
                step(k[2], k[1], k[0], tag_of(model, k[2], k[1], k[0]));
            end
        end
        // saturation under repeated overpayment
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 40; i++)
            step(1'b0, i[0], i[1] | ~i[0], "R6");
        // thirty cents is not paid
        reach(4);
        step(1'b0, 1'b0, 1'b0, "R7");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic c, d, q;
            c = ($urandom % 16) == 0;
            d = $urandom % 2;
            q = ($urandom % 3) == 0;
            step(c, d, q, tag_of(model, c, d, q));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule